// File: doc/BRIEF.md
# Channel-Mapped Interrupt Priority Controller

This block collects up to 64 level-sensitive interrupt requests from peripherals and routes each onto a numbered priority channel through a mapping table that software can program. Every channel has an enable bit and a type bit. The type bit classes the channel as a normal interrupt (IRQ) or a fast interrupt (FIQ). Among the enabled pending channels of each class, the lowest-numbered channel wins. The block drives an IRQ and an FIQ output side by side, each with the winning channel number and that channel's handler address from a per-channel vector table.

Channels 0 and 1 serve a safety function. They are wired straight to requests 0 and 1, cannot be masked, and are always fast. Software that moves a request onto another channel must also move its vector entry, because the vector table is indexed by channel. A word-addressed register port with a combinational read gives access to the mapping words, the enable and type masks, the raw pending flags and the vector table.

Top module: `chan_prio_intc`

## Requirements
- R1: After reset the mapping is the identity (mapping word 0 reads 0x00010203 and word 15 reads 0x3C3D3E3F). Enable and type read 0x00000003 in word 0 and 0 in word 1. Every output is 0.
- R2: Mapping word n (addresses 0..15) serves channels 4n..4n+3. Byte 3 (bits 31:24) serves channel 4n and byte 0 serves channel 4n+3. Each byte carries a 7-bit request number in its bits 6:0. Bit 7 is dropped and reads 0.
- R3: Channels 0 and 1 always follow requests 0 and 1. Writes to their mapping fields are ignored, and those fields read back as 0x00 and 0x01.
- R4: Channels 0 and 1 are always enabled and always FIQ. Their enable and type bits read 1 whatever is written, and they never appear on the IRQ output.
- R5: The lowest pending channel of a class wins. Its number is reported 1-based on irqChan or fiqChan, with 0 meaning none. It appears one clock edge after the requests are sampled.
- R6: Enable set/clear sit at addresses 16/17 and 18/19, and type set/clear at 20/21 and 22/23. Bit j of the second word of each pair is channel 32+j. Writing 1 sets or clears the bit, and writing 0 leaves it alone. A read of either address returns the current mask. A type bit of 1 means FIQ.
- R7: The FIQ and IRQ outputs work independently and may both be active. nextIsFast/nextVec present the FIQ winner whenever one exists, and the IRQ winner otherwise.
- R8: irqVec/fiqVec return the vector entry of the winning channel (address 64+channel), and 0 when nothing wins.
- R9: Pending flags (addresses 24/25) show each channel's mapped request one edge late, regardless of enable or type.
- R10: When several channels map to the same request, all of them become pending together. Only the lowest enabled one wins.
- R11: A disabled channel is pending but never wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | 64 | Level-sensitive peripheral requests |
| busAddr | input | 8 | Register word address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqReq | output | 1 | An enabled IRQ-class channel is pending |
| irqChan | output | 7 | Winning IRQ channel plus one, 0 if none |
| irqVec | output | 32 | Vector of the IRQ winner |
| fiqReq | output | 1 | An enabled FIQ-class channel is pending |
| fiqChan | output | 7 | Winning FIQ channel plus one, 0 if none |
| fiqVec | output | 32 | Vector of the FIQ winner |
| nextIsFast | output | 1 | The more urgent request is an FIQ |
| nextVec | output | 32 | Vector of the more urgent request |

## Verification
Two cases can land in the same cycle. In the first, an IRQ-class channel and an FIQ-class channel are pending together. The bench raises two requests on the same edge after moving one channel to FIQ. It then checks that both outputs carry their own winners and that the urgent pair points to the FIQ. In the second, one request drives two channels after a remap. The bench checks that both pending flags rise on the same edge and that only the lower channel wins, until that channel is disabled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // write strobes from the address decoder to the register datapath
  typedef struct packed {
    logic mapWr;
    logic enSetWr;
    logic enClrWr;
    logic typeSetWr;
    logic typeClrWr;
    logic vecWr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_MAP, RD_EN, RD_TYPE, RD_PEND, RD_VEC
  } rdSel_t;

  localparam int SEL_W = 7;   // request number width in a mapping byte
endpackage

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     cand,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins: scan downward so the last match is the lowest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_CHAN = 64,
  parameter int ADDR_W   = 8,
  parameter int CH_W     = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output wrStrobe_t         strobe,
  output rdSel_t            rdSel,
  output logic [CH_W-1:0]   regIdx
);
  localparam int MapWords  = NUM_CHAN / 4;
  localparam int MaskWords = NUM_CHAN / 32;
  localparam int EnSetBase = MapWords;
  localparam int EnClrBase = EnSetBase + MaskWords;
  localparam int TySetBase = EnClrBase + MaskWords;
  localparam int TyClrBase = TySetBase + MaskWords;
  localparam int PendBase  = TyClrBase + MaskWords;
  localparam int VecBase   = NUM_CHAN;

  logic [ADDR_W-1:0] off;

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    off    = '0;
    if (int'(busAddr) < EnSetBase) begin
      rdSel = RD_MAP;  strobe.mapWr = busWr;  off = busAddr;
    end else if (int'(busAddr) < EnClrBase) begin
      rdSel = RD_EN;   strobe.enSetWr = busWr;
      off = busAddr - ADDR_W'(EnSetBase);
    end else if (int'(busAddr) < TySetBase) begin
      rdSel = RD_EN;   strobe.enClrWr = busWr;
      off = busAddr - ADDR_W'(EnClrBase);
    end else if (int'(busAddr) < TyClrBase) begin
      rdSel = RD_TYPE; strobe.typeSetWr = busWr;
      off = busAddr - ADDR_W'(TySetBase);
    end else if (int'(busAddr) < PendBase) begin
      rdSel = RD_TYPE; strobe.typeClrWr = busWr;
      off = busAddr - ADDR_W'(TyClrBase);
    end else if (int'(busAddr) < PendBase + MaskWords) begin
      rdSel = RD_PEND;
      off = busAddr - ADDR_W'(PendBase);
    end else if (int'(busAddr) >= VecBase && int'(busAddr) < VecBase + NUM_CHAN) begin
      rdSel = RD_VEC;  strobe.vecWr = busWr;
      off = busAddr - ADDR_W'(VecBase);
    end
  end

  assign regIdx = CH_W'(off);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_REQ  = 64,
  parameter int NUM_CHAN = 64,
  parameter int VEC_W    = 32,
  parameter int CH_W     = 6,
  parameter int NUM_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REQ-1:0]  reqIn,
  input  wrStrobe_t           strobe,
  input  rdSel_t              rdSel,
  input  logic [CH_W-1:0]     regIdx,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                irqReq,
  output logic [NUM_W-1:0]    irqChan,
  output logic [VEC_W-1:0]    irqVec,
  output logic                fiqReq,
  output logic [NUM_W-1:0]    fiqChan,
  output logic [VEC_W-1:0]    fiqVec
);
  localparam int MaskWords = NUM_CHAN / 32;
  localparam int RQ_W      = $clog2(NUM_REQ);
  localparam logic [NUM_CHAN-1:0] Fixed = NUM_CHAN'(3);

  logic [SEL_W-1:0]    mapSel [NUM_CHAN];
  logic [VEC_W-1:0]    vecTab [NUM_CHAN];
  logic [NUM_CHAN-1:0] enMask, fiqType, pendFlags, chanRaw, enEff, typeEff;
  logic [NUM_CHAN-1:0] cand [2];
  logic [1:0]          hit;
  logic [CH_W-1:0]     winIdx [2];
  logic                outReq [2];
  logic [NUM_W-1:0]    outNum [2];
  logic [VEC_W-1:0]    outVec [2];
  logic                armed;

  assign enEff   = enMask | Fixed;
  assign typeEff = fiqType | Fixed;

  // request-to-channel routing; the two safety channels are hardwired
  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_route
    if (ch < 2) begin : g_fixed
      assign chanRaw[ch] = reqIn[ch];
    end else begin : g_mapped
      assign chanRaw[ch] = (int'(mapSel[ch]) < NUM_REQ) && reqIn[mapSel[ch][RQ_W-1:0]];
    end
  end

  // mapping table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int ch = 0; ch < NUM_CHAN; ch++) mapSel[ch] <= SEL_W'(ch);
    end else if (strobe.mapWr) begin
      for (int b = 0; b < 4; b++) begin
        if (int'(regIdx) * 4 + b >= 2)
          mapSel[CH_W'(int'(regIdx) * 4 + b)] <= busWdata[8*(3-b) +: SEL_W];
      end
    end
  end

  // enable and type masks with set/clear write semantics
  always_ff @(posedge clk) begin
    if (rst) begin
      enMask  <= '0;
      fiqType <= '0;
    end else begin
      for (int w = 0; w < MaskWords; w++) begin
        if (int'(regIdx) == w) begin
          if (strobe.enSetWr)   enMask[32*w +: 32]  <= enMask[32*w +: 32] | busWdata;
          if (strobe.enClrWr)   enMask[32*w +: 32]  <= enMask[32*w +: 32] & ~busWdata;
          if (strobe.typeSetWr) fiqType[32*w +: 32] <= fiqType[32*w +: 32] | busWdata;
          if (strobe.typeClrWr) fiqType[32*w +: 32] <= fiqType[32*w +: 32] & ~busWdata;
        end
      end
    end
  end

  // vector table, indexed by channel
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int ch = 0; ch < NUM_CHAN; ch++) vecTab[ch] <= '0;
    end else if (strobe.vecWr) begin
      vecTab[regIdx] <= busWdata[VEC_W-1:0];
    end
  end

  assign cand[0] = chanRaw & enEff & ~typeEff;   // IRQ class
  assign cand[1] = chanRaw & enEff & typeEff;    // FIQ class

  for (genvar k = 0; k < 2; k++) begin : g_class
    intc_prio_enc #(.N(NUM_CHAN), .IDX_W(CH_W)) u_enc (
      .cand (cand[k]),
      .hit  (hit[k]),
      .idx  (winIdx[k])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        outReq[k] <= 1'b0;
        outNum[k] <= '0;
        outVec[k] <= '0;
      end else begin
        outReq[k] <= hit[k];
        outNum[k] <= hit[k] ? NUM_W'(winIdx[k]) + NUM_W'(1) : '0;
        outVec[k] <= hit[k] ? vecTab[winIdx[k]] : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendFlags <= '0;
      armed     <= 1'b0;
    end else begin
      pendFlags <= chanRaw;
      armed     <= 1'b1;
    end
  end

  assign irqReq  = outReq[0];
  assign irqChan = outNum[0];
  assign irqVec  = outVec[0];
  assign fiqReq  = outReq[1];
  assign fiqChan = outNum[1];
  assign fiqVec  = outVec[1];

  // register read mux
  always_comb begin
    busRdata = '0;
    case (rdSel)
      RD_MAP: begin
        for (int b = 0; b < 4; b++)
          busRdata[8*(3-b) +: 8] = {1'b0, mapSel[CH_W'(int'(regIdx) * 4 + b)]};
      end
      RD_EN:   for (int w = 0; w < MaskWords; w++) if (int'(regIdx) == w) busRdata = enEff[32*w +: 32];
      RD_TYPE: for (int w = 0; w < MaskWords; w++) if (int'(regIdx) == w) busRdata = typeEff[32*w +: 32];
      RD_PEND: for (int w = 0; w < MaskWords; w++) if (int'(regIdx) == w) busRdata = pendFlags[32*w +: 32];
      RD_VEC:  busRdata = 32'(vecTab[regIdx]);
      default: busRdata = '0;
    endcase
  end

  // request 0 always surfaces as FIQ channel 0 one edge later
  assert_fixed_fiq_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(reqIn[0])) |-> (fiqReq && fiqChan == NUM_W'(1)));
  // the safety channels never reach the IRQ output
  assert_irq_not_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> (irqChan > NUM_W'(2)));
  // request flag and 1-based number agree
  assert_irq_num_valid_R5: assert property (@(posedge clk) disable iff (rst)
    irqReq == (irqChan != '0));
  assert_fiq_num_valid_R5: assert property (@(posedge clk) disable iff (rst)
    fiqReq == (fiqChan != '0));
  // pending flag of channel 1 tracks request 1 with one edge of delay
  assert_pend_track_R9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pendFlags[1] == $past(reqIn[1])));
endmodule

// File: rtl/chan_prio_intc.sv
module chan_prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_REQ  = 64,
  parameter int NUM_CHAN = 64,
  parameter int VEC_W    = 32,
  parameter int ADDR_W   = 8,
  localparam int CH_W    = $clog2(NUM_CHAN),
  localparam int NUM_W   = $clog2(NUM_CHAN + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REQ-1:0]  reqIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                irqReq,
  output logic [NUM_W-1:0]    irqChan,
  output logic [VEC_W-1:0]    irqVec,
  output logic                fiqReq,
  output logic [NUM_W-1:0]    fiqChan,
  output logic [VEC_W-1:0]    fiqVec,
  output logic                nextIsFast,
  output logic [VEC_W-1:0]    nextVec
);
  wrStrobe_t       strobe;
  rdSel_t          rdSel;
  logic [CH_W-1:0] regIdx;

  intc_ctrl #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .regIdx  (regIdx)
  );

  intc_datapath #(
    .NUM_REQ(NUM_REQ), .NUM_CHAN(NUM_CHAN), .VEC_W(VEC_W), .CH_W(CH_W), .NUM_W(NUM_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .reqIn    (reqIn),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .regIdx   (regIdx),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqReq   (irqReq),
    .irqChan  (irqChan),
    .irqVec   (irqVec),
    .fiqReq   (fiqReq),
    .fiqChan  (fiqChan),
    .fiqVec   (fiqVec)
  );

  assign nextIsFast = fiqReq;
  assign nextVec    = fiqReq ? fiqVec : irqVec;

  assert_fast_first_R7: assert property (@(posedge clk) disable iff (rst)
    fiqReq |-> (nextIsFast && nextVec == fiqVec));
  assert_slow_next_R7: assert property (@(posedge clk) disable iff (rst)
    (!fiqReq && irqReq) |-> (!nextIsFast && nextVec == irqVec));
endmodule

// File: tb/chan_prio_intc_bench.sv
module chan_prio_intc_bench;
  localparam int A_EN_SET = 16, A_EN_CLR = 18, A_TY_SET = 20, A_TY_CLR = 22;
  localparam int A_PEND = 24, A_VEC = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] reqIn;
  logic [7:0]  busAddr;
  logic        busWr;
  logic [31:0] busWdata, busRdata;
  logic        irqReq, fiqReq, nextIsFast;
  logic [6:0]  irqChan, fiqChan;
  logic [31:0] irqVec, fiqVec, nextVec;
  int checks = 0, errors = 0;
  logic [31:0] rdv;

  always #4 clk = ~clk;

  chan_prio_intc u_chan_prio_intc (
    .clk(clk), .rst(rst), .reqIn(reqIn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq), .irqChan(irqChan),
    .irqVec(irqVec), .fiqReq(fiqReq), .fiqChan(fiqChan), .fiqVec(fiqVec),
    .nextIsFast(nextIsFast), .nextVec(nextVec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = 8'(addr); busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    busAddr = 8'(addr);
    #1 data = busRdata;
  endtask

  task automatic apply(input logic [63:0] r);
    @(negedge clk);
    reqIn = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd(0, rdv);        check("R1 map word0", rdv, 32'h00010203);
    rd(15, rdv);       check("R1 map word15", rdv, 32'h3C3D3E3F);
    rd(A_EN_SET, rdv); check("R1 enable word0", rdv, 32'h3);
    rd(A_EN_CLR + 1, rdv); check("R1 enable word1", rdv, 32'h0);
    rd(A_TY_SET, rdv); check("R1 type word0", rdv, 32'h3);
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 fiqReq", 32'(fiqReq), 0);
    check("R1 irqChan", 32'(irqChan), 0);
    check("R1 nextVec", nextVec, 0);
  endtask

  task automatic t_fixed();
    wr(A_EN_CLR, 32'hFFFFFFFF);
    wr(A_TY_CLR, 32'hFFFFFFFF);
    rd(A_EN_SET, rdv); check("R4 enable bits 0/1 stay set", rdv, 32'h3);
    rd(A_TY_SET, rdv); check("R4 type bits 0/1 stay FIQ", rdv, 32'h3);
    wr(0, 32'h05050505);
    rd(0, rdv); check("R3 fixed mapping fields", rdv, 32'h00010505);
    apply(64'h1);
    check("R3 req0 fiqReq", 32'(fiqReq), 1);
    check("R3 req0 fiqChan", 32'(fiqChan), 1);
    check("R4 req0 not IRQ", 32'(irqReq), 0);
    apply(64'h2);
    check("R4 req1 fiqChan", 32'(fiqChan), 2);
    apply(64'h0);
    wr(0, 32'h00010203);
  endtask

  task automatic t_prio();
    wr(A_VEC + 5, 32'h100);
    wr(A_VEC + 9, 32'h200);
    wr(A_VEC + 63, 32'h3F0);
    wr(A_EN_SET, 32'hFFFFFFFC);
    wr(A_EN_SET + 1, 32'hFFFFFFFF);
    @(negedge clk);
    reqIn = (64'h1 << 5) | (64'h1 << 9);
    #1 check("R5 no change before edge", 32'(irqReq), 0);
    @(negedge clk);
    check("R5 lowest wins irqChan", 32'(irqChan), 6);
    check("R8 irqVec of ch5", irqVec, 32'h100);
    apply(64'h1 << 63);
    check("R5 top channel irqChan", 32'(irqChan), 64);
    check("R8 irqVec of ch63", irqVec, 32'h3F0);
    apply(64'h0);
    check("R5 none pending irqChan", 32'(irqChan), 0);
  endtask

  task automatic t_type();
    wr(A_TY_SET, 32'h1 << 9);
    apply((64'h1 << 5) | (64'h1 << 9));
    check("R7 irqChan with both", 32'(irqChan), 6);
    check("R7 fiqChan with both", 32'(fiqChan), 10);
    check("R7 fiqVec", fiqVec, 32'h200);
    check("R7 nextIsFast", 32'(nextIsFast), 1);
    check("R7 nextVec FIQ", nextVec, 32'h200);
    apply(64'h1 << 5);
    check("R7 nextIsFast IRQ only", 32'(nextIsFast), 0);
    check("R7 nextVec IRQ", nextVec, 32'h100);
    wr(A_TY_CLR, 32'h1 << 9);
    rd(A_TY_CLR, rdv); check("R6 type clear", rdv, 32'h3);
    apply(64'h0);
  endtask

  task automatic t_setclr();
    wr(A_EN_CLR, 32'h1 << 5);
    rd(A_EN_SET, rdv); check("R6 enable clear one bit", rdv, 32'hFFFFFFDF);
    wr(A_EN_SET, 32'h0);
    rd(A_EN_CLR, rdv); check("R6 zero write no effect", rdv, 32'hFFFFFFDF);
    apply(64'h1 << 5);
    check("R11 disabled ch5 no irq", 32'(irqReq), 0);
    rd(A_PEND, rdv); check("R9 pending raw ch5", rdv, 32'h20);
    wr(A_EN_SET, 32'h1 << 5);
    apply(64'h0);
  endtask

  task automatic t_remap();
    wr(A_VEC + 3, 32'hA3);
    wr(A_VEC + 40, 32'hA8);
    wr(0, 32'h000102A8);
    rd(0, rdv); check("R2 field bit7 dropped", rdv, 32'h00010228);
    apply(64'h1 << 40);
    rd(A_PEND, rdv);     check("R10 pend ch3", rdv, 32'h8);
    rd(A_PEND + 1, rdv); check("R10 pend ch40", rdv, 32'h100);
    check("R10 lowest of shared irqChan", 32'(irqChan), 4);
    check("R8 vector by channel", irqVec, 32'hA3);
    wr(A_EN_CLR, 32'h1 << 3);
    @(negedge clk);
    check("R10 next shared channel wins", 32'(irqChan), 41);
    check("R8 vector of ch40", irqVec, 32'hA8);
    apply(64'h0);
    wr(1, 32'h07060504);
    apply(64'h1 << 7);
    rd(A_PEND, rdv); check("R2 top byte maps lowest channel", rdv, 32'h10);
    check("R2 irqChan ch4", 32'(irqChan), 5);
    apply(64'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; reqIn = '0; busAddr = '0; busWr = 1'b0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fixed();
    t_prio();
    t_type();
    t_setclr();
    t_remap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule